// File: doc/BRIEF.md
# Broadcast Data Packet Hamming Extractor

This block sits behind a teletext slicer and byte framer. It receives the bytes of one packet at a time, already aligned, and counts their positions from the strobe that marks the first byte. It accepts only packets that the framer marks as service-data rows (row 8/30). Of those, it takes a fixed slice of positions, which depends on the packet's format, and writes each byte of that slice to a staging buffer.

The date/time format (format 1) is copied into the buffer bit for bit and raises no flag. Every byte of the programme-label format (format 2) goes through a Hamming 8/4 decoder. A single-bit error is corrected, and only the 4-bit data nibble is written. When a whole format-2 slice has been written without an uncorrectable byte, the block pulses a commit request. Downstream logic uses this pulse to copy the staging buffer into the host-visible register set and to signal that data is available.

If a format-2 byte holds two flipped bits, the packet is dropped. Nothing more is written for that packet and no commit is issued.

Top module: `bdsp_extract`

## Requirements
- R1: After reset and with no input, `wr_en` and `commit` stay low.
- R2: A packet whose first byte arrives with `in_row_ok` low causes no write and no commit.
- R3: Byte positions start at 1 on the byte carrying `in_start`. For format 2, positions 13 to 25 are written to addresses 0 to 12, one write per byte, in order. Each write appears on the outputs one clock after the byte is accepted.
- R4: For format 1 (`in_fmt2` low at the start), positions 15 to 21 are written to addresses 13 to 19, and `wr_data` equals the received byte unchanged.
- R5: A format-2 write carries the decoded nibble {b7,b5,b3,b1} in `wr_data[3:0]`, with bits 7:4 zero. The byte uses odd-parity checks: b0^b1^b5^b7, b1^b2^b3^b7, b1^b3^b4^b5 and the XOR of all eight bits each equal 1 in a clean byte.
- R6: A format-2 byte with exactly one flipped bit, at any of its eight positions, is written with the nibble it was encoded from.
- R7: `commit` is a one-cycle pulse. It rises one clock after the write of format-2 position 25, and only when every format-2 byte of that packet was clean or correctable.
- R8: A format-1 packet never raises `commit`.
- R9: A format-2 byte with two flipped bits is not written. No later byte of that packet is written, and no commit follows.
- R10: Cycles with `in_valid` low do not advance the byte position, so gaps inside a packet change neither the data nor the addresses.
- R11: A new `in_start` in the middle of a packet abandons the old packet: its remaining slice is not written and it raises no commit.
- R12: Bytes outside a format's slice, including bytes past position 25 and bytes past the packet length, cause no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A packet byte is present on `in_byte` |
| in_start | input | 1 | With `in_valid`: this byte is position 1 of a new packet |
| in_row_ok | input | 1 | With `in_start`: the packet is a service-data row |
| in_fmt2 | input | 1 | With `in_start`: 1 for format 2, 0 for format 1 |
| in_byte | input | 8 | Packet byte, bit 0 first on the line |
| wr_en | output | 1 | Staging-buffer write strobe |
| wr_addr | output | 5 | Staging slot: 0..12 for format 2, 13..19 for format 1 |
| wr_data | output | 8 | Nibble (format 2) or raw byte (format 1) |
| commit | output | 1 | One-cycle request to publish a clean format-2 packet |

## Verification
The assertions check, on every cycle:
- the commit pulse lasts one cycle and follows directly on a write to the last format-2 slot;
- every write lands in a valid slot;
- format-2 writes have a zero upper nibble;
- format-1 writes copy the byte accepted one cycle earlier.

Only the bench scenarios can show the following, because each one depends on the history of a whole packet:
- which positions fall inside the slices;
- that single errors at each bit position are repaired;
- that a double error suppresses the rest of the packet;
- that gaps and restarts behave correctly.

// File: rtl/bdsp_pkg.sv
package bdsp_pkg;

    typedef enum logic {
        FMT_ONE = 1'b0,
        FMT_TWO = 1'b1
    } bdsp_fmt_e;

    typedef struct packed {
        logic [3:0] nib;
        logic       dbl;
    } ham_res_t;

endpackage

// File: rtl/bdsp_ham84_dec.sv
// Hamming 8/4 check-and-correct. Bit 0 is the first bit on the line.
// Protection bits sit in b0, b2, b4, b6; data d1..d4 sit in b1, b3, b5, b7.
module bdsp_ham84_dec (
    input  logic [7:0]         code,
    output bdsp_pkg::ham_res_t res
);
    logic       ck_a, ck_b, ck_c, ck_all;
    logic [2:0] miss;
    logic [7:0] flip;
    logic [7:0] fixed;

    always_comb begin
        ck_a   = code[0] ^ code[1] ^ code[5] ^ code[7];
        ck_b   = code[1] ^ code[2] ^ code[3] ^ code[7];
        ck_c   = code[1] ^ code[3] ^ code[4] ^ code[5];
        ck_all = ^code;
        miss   = {~ck_a, ~ck_b, ~ck_c};
        flip   = '0;
        res.dbl = 1'b0;
        if (miss != 3'b000) begin
            if (ck_all) begin
                // overall parity fine but a group check failed: two errors
                res.dbl = 1'b1;
            end else begin
                unique case (miss)
                    3'b100:  flip[0] = 1'b1;
                    3'b111:  flip[1] = 1'b1;
                    3'b010:  flip[2] = 1'b1;
                    3'b011:  flip[3] = 1'b1;
                    3'b001:  flip[4] = 1'b1;
                    3'b101:  flip[5] = 1'b1;
                    3'b110:  flip[7] = 1'b1;
                    default: flip    = '0;
                endcase
            end
        end
        // an error on b6 alone touches no data bit, so nothing to flip
        fixed   = code ^ flip;
        res.nib = {fixed[7], fixed[5], fixed[3], fixed[1]};
    end
endmodule

// File: rtl/bdsp_window.sv
// Decides whether a byte position falls inside one format's slice.
module bdsp_window #(
    parameter int IDX_W  = 6,
    parameter int ADDR_W = 5,
    parameter int FIRST  = 13,
    parameter int COUNT  = 13,
    parameter int BASE   = 0
) (
    input  logic [IDX_W-1:0]  pos,
    output logic              hit,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int LAST = FIRST + COUNT - 1;

    logic [IDX_W-1:0] offset;

    always_comb begin
        hit    = (pos >= IDX_W'(FIRST)) && (pos <= IDX_W'(LAST));
        offset = pos - IDX_W'(FIRST);
        addr   = ADDR_W'(BASE) + ADDR_W'(offset);
        last   = (pos == IDX_W'(LAST));
    end
endmodule

// File: rtl/bdsp_extract.sv
module bdsp_extract #(
    parameter int PKT_BYTES = 45,
    parameter int F2_FIRST  = 13,
    parameter int F2_COUNT  = 13,
    parameter int F1_FIRST  = 15,
    parameter int F1_COUNT  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_start,
    input  logic       in_row_ok,
    input  logic       in_fmt2,
    input  logic [7:0] in_byte,
    output logic       wr_en,
    output logic [4:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       commit
);
    import bdsp_pkg::*;

    localparam int SLOTS  = F2_COUNT + F1_COUNT;
    localparam int ADDR_W = 5;
    localparam int IDX_W  = $clog2(PKT_BYTES + 2);
    localparam int N_FMT  = 2;

    typedef struct packed {
        logic              active;
        bdsp_fmt_e         fmt;
        logic              bad;
        logic [IDX_W-1:0]  next;
        logic              pend;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [7:0]        wr_data;
        logic              commit;
    } state_t;

    state_t st_d, st_q;

    logic [IDX_W-1:0]  pos;
    bdsp_fmt_e         cur_fmt;
    logic              cur_bad;
    logic              take;
    ham_res_t          ham;
    logic [N_FMT-1:0]  win_hit;
    logic [N_FMT-1:0]  win_last;
    logic [ADDR_W-1:0] win_addr [N_FMT];

    bdsp_ham84_dec u_ham (
        .code (in_byte),
        .res  (ham)
    );

    // slot 0 handles format 1, slot 1 handles format 2
    for (genvar g = 0; g < N_FMT; g++) begin : g_win
        localparam int FIRST = (g == 1) ? F2_FIRST : F1_FIRST;
        localparam int COUNT = (g == 1) ? F2_COUNT : F1_COUNT;
        localparam int BASE  = (g == 1) ? 0 : F2_COUNT;
        bdsp_window #(
            .IDX_W  (IDX_W),
            .ADDR_W (ADDR_W),
            .FIRST  (FIRST),
            .COUNT  (COUNT),
            .BASE   (BASE)
        ) u_win (
            .pos  (pos),
            .hit  (win_hit[g]),
            .addr (win_addr[g]),
            .last (win_last[g])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.wr_en  = 1'b0;
        st_d.commit = st_q.pend;
        st_d.pend   = 1'b0;

        pos     = in_start ? IDX_W'(1) : st_q.next;
        cur_fmt = in_start ? (in_fmt2 ? FMT_TWO : FMT_ONE) : st_q.fmt;
        cur_bad = in_start ? 1'b0 : st_q.bad;
        take    = in_valid && (in_start ? in_row_ok : st_q.active);

        if (in_valid && in_start) begin
            st_d.active = in_row_ok;
            st_d.fmt    = cur_fmt;
            st_d.bad    = 1'b0;
        end

        if (take) begin
            if (pos >= IDX_W'(PKT_BYTES)) begin
                st_d.active = 1'b0;
                st_d.next   = pos;
            end else begin
                st_d.next = pos + IDX_W'(1);
            end

            if (cur_fmt == FMT_TWO) begin
                if (win_hit[1] && !cur_bad) begin
                    if (ham.dbl) begin
                        st_d.bad = 1'b1;
                    end else begin
                        st_d.wr_en   = 1'b1;
                        st_d.wr_addr = win_addr[1];
                        st_d.wr_data = {4'b0000, ham.nib};
                        st_d.pend    = win_last[1];
                    end
                end
            end else if (win_hit[0]) begin
                st_d.wr_en   = 1'b1;
                st_d.wr_addr = win_addr[0];
                st_d.wr_data = in_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = st_q.wr_en;
    assign wr_addr = st_q.wr_addr;
    assign wr_data = st_q.wr_data;
    assign commit  = st_q.commit;

    initial begin
        assert (SLOTS <= (1 << ADDR_W))
            else $error("staging slots exceed the address width");
    end
endmodule

// File: rtl/bdsp_extract_chk.sv
module bdsp_extract_chk #(
    parameter int F2_COUNT = 13,
    parameter int F1_COUNT = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       wr_en,
    input logic [4:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       commit
);
    localparam int SLOTS = F2_COUNT + F1_COUNT;

    // R7: the publish request lasts exactly one cycle
    assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R7: the request comes right after the write to the last format-2 slot
    assert_commit_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($past(wr_en) && ($past(wr_addr) == 5'(F2_COUNT - 1))));

    // R3: every write stays inside the staging buffer
    assert_addr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < 5'(SLOTS)));

    // R3: a write needs a byte accepted in the previous cycle
    assert_write_needs_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid));

    // R5: format-2 slots carry a nibble only
    assert_nibble_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr < 5'(F2_COUNT))) |-> (wr_data[7:4] == 4'h0));

    // R4: format-1 slots hold the received byte untouched
    assert_raw_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr >= 5'(F2_COUNT))) |-> (wr_data == $past(in_byte)));
endmodule

bind bdsp_extract bdsp_extract_chk #(
    .F2_COUNT (F2_COUNT),
    .F1_COUNT (F1_COUNT)
) u_chk (.*);

// File: tb/bdsp_extract_test.sv
module bdsp_extract_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_start = 1'b0;
    logic       in_row_ok = 1'b0;
    logic       in_fmt2 = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       wr_en;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;
    logic       commit;

    always #5 clk = ~clk;

    bdsp_extract uut (.*);

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input logic [3:0] n);
        logic [7:0] b;
        b[1] = n[0]; b[3] = n[1]; b[5] = n[2]; b[7] = n[3];
        b[0] = ~(n[0] ^ n[2] ^ n[3]);
        b[2] = ~(n[0] ^ n[1] ^ n[3]);
        b[4] = ~(n[0] ^ n[1] ^ n[2]);
        b[6] = ~(b[0] ^ b[1] ^ b[2] ^ b[3] ^ b[4] ^ b[5] ^ b[7]);
        return b;
    endfunction

    // nearest codeword search; -1 when no codeword lies within one bit
    function automatic int dec(input logic [7:0] c);
        for (int n = 0; n < 16; n++) begin
            if ($countones(c ^ enc(4'(n))) <= 1) return n;
        end
        return -1;
    endfunction

    // ---------------- behavioural reference, cycle by cycle -------------
    int m_next = 0, m_act = 0, m_f2 = 0, m_bad = 0, m_pend = 0;
    int e_wr = 0, e_addr = 0, e_data = 0, e_cm = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_next = 0; m_act = 0; m_f2 = 0; m_bad = 0; m_pend = 0;
            e_wr = 0; e_addr = 0; e_data = 0; e_cm = 0;
        end else begin
            int p;
            int live;
            e_cm   = m_pend;
            m_pend = 0;
            e_wr   = 0;
            if (in_valid) begin
                if (in_start) begin
                    m_act = in_row_ok; m_f2 = in_fmt2; m_bad = 0; p = 1; live = in_row_ok;
                end else begin
                    p = m_next; live = m_act;
                end
                if (live != 0) begin
                    if (p >= 45) m_act = 0;
                    m_next = (p >= 45) ? p : p + 1;
                    if (m_f2 != 0 && p >= 13 && p <= 25 && m_bad == 0) begin
                        int v;
                        v = dec(in_byte);
                        if (v < 0) m_bad = 1;
                        else begin
                            e_wr = 1; e_addr = p - 13; e_data = v;
                            if (p == 25) m_pend = 1;
                        end
                    end else if (m_f2 == 0 && p >= 15 && p <= 21) begin
                        e_wr = 1; e_addr = 13 + p - 15; e_data = in_byte;
                    end
                end
            end
        end
    end

    // ---------------- observation, away from the active edge -------------
    int obs_wr = 0, obs_cm = 0;
    logic [7:0] got [0:19];

    always @(negedge clk) begin
        if (rst_n) begin
            check(wr_en == e_wr[0], "R3 wr_en", int'(wr_en), e_wr);
            check(commit == e_cm[0], "R7 commit", int'(commit), e_cm);
            if (e_wr != 0) begin
                check(wr_addr == 5'(e_addr), "R3 wr_addr", int'(wr_addr), e_addr);
                check(wr_data == 8'(e_data), e_addr < 13 ? "R5 nibble" : "R4 raw byte",
                      int'(wr_data), e_data);
            end
            if (wr_en) begin
                obs_wr++;
                if (wr_addr < 5'd20) got[wr_addr] = wr_data;
            end
            if (commit) obs_cm++;
        end
    end

    // ---------------- stimulus -------------------------------------------
    logic [7:0] pkt  [1:45];
    logic [7:0] flip [1:45];
    logic [3:0] nib  [0:12];

    task automatic make(input int seed);
        for (int i = 1; i <= 45; i++) begin
            pkt[i]  = 8'(i * 29 + seed * 7);
            flip[i] = 8'h00;
        end
        for (int i = 13; i <= 25; i++) begin
            nib[i-13] = 4'(i * 3 + seed);
            pkt[i]    = enc(nib[i-13]);
        end
    endtask

    task automatic send(input bit row, input bit f2, input int nbytes, input bit gaps);
        for (int i = 1; i <= nbytes; i++) begin
            if (gaps && (i % 3 == 0)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_byte  = 8'hA5;
            end
            @(negedge clk);
            in_valid  = 1'b1;
            in_start  = (i == 1);
            in_row_ok = row;
            in_fmt2   = f2;
            in_byte   = pkt[i] ^ flip[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_obs();
        obs_wr = 0;
        obs_cm = 0;
        for (int k = 0; k < 20; k++) got[k] = 8'hEE;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        clear_obs();
        idle(4);
        // R1: quiet after reset
        check(wr_en == 1'b0 && commit == 1'b0, "R1 reset outputs", int'({wr_en, commit}), 0);
        check(obs_wr == 0, "R1 no writes", obs_wr, 0);

        // clean format 2
        make(1); clear_obs();
        send(1'b1, 1'b1, 45, 1'b0); idle(3);
        check(obs_wr == 13, "R3 write count", obs_wr, 13);
        check(obs_wr == 13, "R12 nothing beyond slice", obs_wr, 13);
        check(obs_cm == 1, "R7 one commit", obs_cm, 1);
        for (int k = 0; k < 13; k++)
            check(got[k] == {4'h0, nib[k]}, "R5 decoded nibble", int'(got[k]), int'(nib[k]));

        // single-bit errors at every bit position
        make(2); clear_obs();
        for (int i = 13; i <= 25; i++) flip[i] = 8'(1 << ((i - 13) % 8));
        send(1'b1, 1'b1, 45, 1'b0); idle(3);
        for (int k = 0; k < 13; k++)
            check(got[k] == {4'h0, nib[k]}, "R6 corrected nibble", int'(got[k]), int'(nib[k]));
        check(obs_cm == 1, "R6 commit after correction", obs_cm, 1);

        // format 1 raw
        make(3); clear_obs();
        send(1'b1, 1'b0, 45, 1'b0); idle(3);
        check(obs_wr == 7, "R4 write count", obs_wr, 7);
        for (int k = 0; k < 7; k++)
            check(got[13+k] == pkt[15+k], "R4 raw copy", int'(got[13+k]), int'(pkt[15+k]));
        check(obs_cm == 0, "R8 no commit for format 1", obs_cm, 0);

        // other rows ignored
        make(4); clear_obs();
        send(1'b0, 1'b1, 45, 1'b0); idle(3);
        check(obs_wr == 0, "R2 no writes", obs_wr, 0);
        check(obs_cm == 0, "R2 no commit", obs_cm, 0);

        // double error at position 18
        make(5); clear_obs();
        flip[18] = 8'h06;
        send(1'b1, 1'b1, 45, 1'b0); idle(3);
        check(obs_wr == 5, "R9 writes stop", obs_wr, 5);
        check(obs_cm == 0, "R9 no commit", obs_cm, 0);

        // gaps inside the packet
        make(6); clear_obs();
        send(1'b1, 1'b1, 45, 1'b1); idle(3);
        check(obs_wr == 13, "R10 write count with gaps", obs_wr, 13);
        check(obs_cm == 1, "R10 commit with gaps", obs_cm, 1);
        check(got[12] == {4'h0, nib[12]}, "R10 last slot", int'(got[12]), int'(nib[12]));

        // restart mid-packet
        make(7); clear_obs();
        send(1'b1, 1'b1, 20, 1'b0);
        make(8);
        send(1'b1, 1'b0, 45, 1'b0); idle(3);
        check(obs_wr == 15, "R11 writes across restart", obs_wr, 15);
        check(obs_cm == 0, "R11 no commit", obs_cm, 0);

        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule